// File: doc/BRIEF.md
# One-Shot ECC Fault-Injection Read Path

This block sits between the two read ports of an ECC-protected memory and the logic that consumes their data. Each port returns a 72-bit codeword: 64 data bits and 8 check bits. The block passes that codeword through a SECDED decoder, so a single-bit error is repaired and a double-bit error is reported. Read data and status are registered and appear one clock after the request.

Software exercises the decoder through a small write-only register interface. It loads a 64-bit data flip mask and an 8-bit check flip mask. It then writes the control register with the diagnostic mode set to 7, the trigger bit set, and a port select code. The next read on the chosen port has both masks XORed into its codeword before decode. The block then disarms itself, so every other read is left untouched. With this, a test routine can walk all 72 single-bit and all 2556 double-bit patterns one read at a time.

Sticky status bits record corrected errors, uncorrectable errors and illegal configuration attempts. The block also holds the port and address of the most recent flagged read. An uncorrectable read raises a one-cycle fast interrupt request.

Top module: `ecc_inject_rdpath`

## Requirements
- R1: A read request on either port gives `x_rvalid` high with the decoded data on `x_rdata` exactly one clock later. Status bits and `fiq_req` update on that same edge.
- R2: A write to `cfg_sel`=0 arms injection only when it carries trigger `cfg_wdata[4]`=1, mode `cfg_wdata[3:0]`=7 and a legal port select `cfg_wdata[10:8]` (0 selects port A, 4 selects port B). Any other write to that register leaves the block unarmed, and with no such write an unarmed block stays unarmed. `diag_armed` shows the state.
- R3: On the first read on the targeted port while armed, the memory data is XORed with the data mask (`cfg_sel`=1, full word) and the check bits with the check mask (`cfg_sel`=2, bits 7:0) before decode. That read disarms the block, and the next read on that port is delivered unmodified.
- R4: While armed, a read on the port that is not targeted is delivered unmodified and leaves the block armed.
- R5: Reads made while the block is unarmed return the stored data and flag no error.
- R6: A trigger write with mode 7 and a port select other than 0 or 4 leaves the block unarmed and sets `cfg_err_sts`.
- R7: Codeword layout: data bit i occupies the i-th Hamming position (counting from 1) that is not a power of two, so bit 0 is at position 3, bit 1 at 5, bit 2 at 6 and so on. Check bit j (j<7) is the even parity of every position whose index has bit j set. Check bit 7 is the even parity of all other 71 bits.
- R8: A single flipped bit anywhere in the 72 is corrected, so the stored data is returned, and `sec_sts` is set.
- R9: Two flipped bits set `ded_sts`, return the data bits exactly as received, and pulse `fiq_req` for one cycle together with `x_rvalid`.
- R10: Every read that flags an error loads its port (0=A, 1=B) into `err_port` and its address into `err_addr`.
- R11: A write to `cfg_sel`=3 clears a status item for each 1 written: bit 0 `sec_sts`, bit 1 `ded_sts`, bit 2 `cfg_err_sts`, bit 3 `err_port` and `err_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 data mask, 2 check mask, 3 status clear |
| cfg_wdata | input | DATA_W | Register write data |
| a_req | input | 1 | Port A read request |
| a_addr | input | ADDR_W | Port A read address |
| a_mem_data | input | DATA_W | Port A stored data from memory |
| a_mem_chk | input | CHK_W | Port A stored check bits from memory |
| a_rvalid | output | 1 | Port A read data valid |
| a_rdata | output | DATA_W | Port A decoded data |
| b_req | input | 1 | Port B read request |
| b_addr | input | ADDR_W | Port B read address |
| b_mem_data | input | DATA_W | Port B stored data from memory |
| b_mem_chk | input | CHK_W | Port B stored check bits from memory |
| b_rvalid | output | 1 | Port B read data valid |
| b_rdata | output | DATA_W | Port B decoded data |
| diag_armed | output | 1 | Injection armed |
| sec_sts | output | 1 | Sticky corrected-error flag |
| ded_sts | output | 1 | Sticky uncorrectable-error flag |
| cfg_err_sts | output | 1 | Sticky illegal-configuration flag |
| err_port | output | 1 | Port of last flagged read |
| err_addr | output | ADDR_W | Address of last flagged read |
| fiq_req | output | 1 | Fast interrupt pulse on an uncorrectable read |

## Verification
On every cycle the checker enforces the one-cycle read latency, the arming rules and the one-shot disarm. It also checks that a read on the non-targeted port keeps the block armed, that an illegal port select is rejected and flagged, and that the interrupt is never raised without the uncorrectable flag. The decoder's arithmetic can only be shown by the bench scenarios: that every one of the 72 single flips is corrected, and that all 2556 double flips are detected with the raw data passed through. The same holds for the error port and address capture, the write-1-to-clear behaviour, and that the read after an injected one comes back clean.

// File: rtl/ecc_diag_pkg.sv
package ecc_diag_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_DMASK = 2'd1,
    SEL_EMASK = 2'd2,
    SEL_STS   = 2'd3
  } cfg_sel_e;

  localparam logic [3:0] DIAG_MODE_INJ = 4'd7;
  localparam logic [2:0] BSEL_PORT_A   = 3'd0;
  localparam logic [2:0] BSEL_PORT_B   = 3'd4;

  // Hamming check bits needed for dw data bits (without overall parity)
  function automatic int hbits(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // Hamming position of data bit i: skip every power-of-two slot
  function automatic int hpos(input int i);
    int p;
    int k;
    p = i + 3;
    k = 4;
    while (k <= p) begin
      p++;
      k = k << 1;
    end
    return p;
  endfunction

endpackage

// File: rtl/secded_dec.sv
module secded_dec
  import ecc_diag_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = hbits(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sec_o,
  output logic              ded_o
);
  localparam int HB = CHK_W - 1;

  logic [HB-1:0] syn;
  logic          ovr;
  logic          hit;
  int            p;

  always_comb begin
    syn = chk_i[HB-1:0];
    for (int i = 0; i < DATA_W; i++) begin
      p = hpos(i);
      for (int j = 0; j < HB; j++) begin
        if (p[j]) syn[j] = syn[j] ^ data_i[i];
      end
    end
    ovr    = ^{chk_i, data_i};
    data_o = data_i;
    hit    = 1'b0;
    sec_o  = 1'b0;
    ded_o  = 1'b0;
    if (ovr) begin
      for (int i = 0; i < DATA_W; i++) begin
        if (hpos(i) == int'(syn)) begin
          data_o[i] = ~data_i[i];
          hit       = 1'b1;
        end
      end
      if (hit || (syn == '0) || $onehot(syn)) sec_o = 1'b1;
      else                                     ded_o = 1'b1;
    end else if (syn != '0) begin
      ded_o = 1'b1;
    end
  end

endmodule

// File: rtl/inj_ctrl.sv
module inj_ctrl
  import ecc_diag_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = hbits(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [1:0]        req,
  output logic [1:0]        inject,
  output logic              armed,
  output logic              tgt_b,
  output logic              cfg_bad,
  output logic [DATA_W-1:0] dmask,
  output logic [CHK_W-1:0]  emask
);
  logic [DATA_W-1:0] dmask_n;
  logic [CHK_W-1:0]  emask_n;
  logic              armed_n, tgt_n;
  logic              ctrl_wr, trig, mode_ok, bsel_ok;
  logic [2:0]        bsel;

  assign ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL);
  assign trig    = cfg_wdata[4];
  assign bsel    = cfg_wdata[10:8];
  assign mode_ok = (cfg_wdata[3:0] == DIAG_MODE_INJ);
  assign bsel_ok = (bsel == BSEL_PORT_A) || (bsel == BSEL_PORT_B);
  assign cfg_bad = ctrl_wr && trig && mode_ok && !bsel_ok;

  assign inject[0] = armed && !tgt_b && req[0];
  assign inject[1] = armed &&  tgt_b && req[1];

  always_comb begin
    dmask_n = dmask;
    emask_n = emask;
    armed_n = armed && !(|inject);
    tgt_n   = tgt_b;
    if (cfg_we && (cfg_sel == SEL_DMASK)) dmask_n = cfg_wdata;
    if (cfg_we && (cfg_sel == SEL_EMASK)) emask_n = cfg_wdata[CHK_W-1:0];
    if (ctrl_wr) begin
      armed_n = trig && mode_ok && bsel_ok;
      if (trig && bsel_ok) tgt_n = bsel[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmask <= '0;
      emask <= '0;
      armed <= 1'b0;
      tgt_b <= 1'b0;
    end else begin
      dmask <= dmask_n;
      emask <= emask_n;
      armed <= armed_n;
      tgt_b <= tgt_n;
    end
  end

endmodule

// File: rtl/port_path.sv
module port_path
  import ecc_diag_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = hbits(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              inject,
  input  logic [DATA_W-1:0] mem_data,
  input  logic [CHK_W-1:0]  mem_chk,
  input  logic [DATA_W-1:0] dmask,
  input  logic [CHK_W-1:0]  emask,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic              sec_c,
  output logic              ded_c
);
  logic [DATA_W-1:0] cw_data, dec_data;
  logic [CHK_W-1:0]  cw_chk;
  logic              dec_sec, dec_ded;

  assign cw_data = inject ? (mem_data ^ dmask) : mem_data;
  assign cw_chk  = inject ? (mem_chk ^ emask) : mem_chk;

  secded_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
    .data_i (cw_data),
    .chk_i  (cw_chk),
    .data_o (dec_data),
    .sec_o  (dec_sec),
    .ded_o  (dec_ded)
  );

  assign sec_c = req && dec_sec;
  assign ded_c = req && dec_ded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= req;
      if (req) rdata <= dec_data;
    end
  end

endmodule

// File: rtl/ecc_inject_rdpath.sv
module ecc_inject_rdpath
  import ecc_diag_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  parameter int CHK_W  = hbits(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              a_req,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_mem_data,
  input  logic [CHK_W-1:0]  a_mem_chk,
  output logic              a_rvalid,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_req,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_mem_data,
  input  logic [CHK_W-1:0]  b_mem_chk,
  output logic              b_rvalid,
  output logic [DATA_W-1:0] b_rdata,
  output logic              diag_armed,
  output logic              sec_sts,
  output logic              ded_sts,
  output logic              cfg_err_sts,
  output logic              err_port,
  output logic [ADDR_W-1:0] err_addr,
  output logic              fiq_req
);
  localparam int NPORT = 2;

  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  logic [NPORT-1:0]  req, inject, sec_c, ded_c, rvalid;
  logic [DATA_W-1:0] rdata [NPORT];
  logic [DATA_W-1:0] mem_data [NPORT];
  logic [CHK_W-1:0]  mem_chk [NPORT];
  logic [DATA_W-1:0] dmask;
  logic [CHK_W-1:0]  emask;
  logic              arm_tgt_b, cfg_bad;
  logic [3:0]        clr;
  logic              sec_n, ded_n, cfg_n, port_n, fiq_n;
  logic [ADDR_W-1:0] addr_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  assign req      = {b_req, a_req};
  assign mem_data[0] = a_mem_data;
  assign mem_data[1] = b_mem_data;
  assign mem_chk[0]  = a_mem_chk;
  assign mem_chk[1]  = b_mem_chk;

  inj_ctrl #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .req       (req),
    .inject    (inject),
    .armed     (diag_armed),
    .tgt_b     (arm_tgt_b),
    .cfg_bad   (cfg_bad),
    .dmask     (dmask),
    .emask     (emask)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    port_path #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_path (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .req      (req[g]),
      .inject   (inject[g]),
      .mem_data (mem_data[g]),
      .mem_chk  (mem_chk[g]),
      .dmask    (dmask),
      .emask    (emask),
      .rvalid   (rvalid[g]),
      .rdata    (rdata[g]),
      .sec_c    (sec_c[g]),
      .ded_c    (ded_c[g])
    );
  end

  assign a_rvalid = rvalid[0];
  assign b_rvalid = rvalid[1];
  assign a_rdata  = rdata[0];
  assign b_rdata  = rdata[1];

  assign clr = (cfg_we && (cfg_sel == SEL_STS)) ? cfg_wdata[3:0] : 4'b0;

  always_comb begin
    sec_n  = (sec_sts     && !clr[0]) || (|sec_c);
    ded_n  = (ded_sts     && !clr[1]) || (|ded_c);
    cfg_n  = (cfg_err_sts && !clr[2]) || cfg_bad;
    fiq_n  = |ded_c;
    port_n = err_port;
    addr_n = err_addr;
    if (clr[3]) begin
      port_n = 1'b0;
      addr_n = '0;
    end
    if (sec_c[0] || ded_c[0]) begin
      port_n = 1'b0;
      addr_n = a_addr;
    end else if (sec_c[1] || ded_c[1]) begin
      port_n = 1'b1;
      addr_n = b_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sec_sts     <= 1'b0;
      ded_sts     <= 1'b0;
      cfg_err_sts <= 1'b0;
      err_port    <= 1'b0;
      err_addr    <= '0;
      fiq_req     <= 1'b0;
    end else begin
      sec_sts     <= sec_n;
      ded_sts     <= ded_n;
      cfg_err_sts <= cfg_n;
      err_port    <= port_n;
      err_addr    <= addr_n;
      fiq_req     <= fiq_n;
    end
  end

endmodule

// File: rtl/ecc_inject_rdpath_chk.sv
module ecc_inject_rdpath_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              a_req,
  input logic              b_req,
  input logic              a_rvalid,
  input logic              b_rvalid,
  input logic              diag_armed,
  input logic              tgt_b,
  input logic              fiq_req,
  input logic              ded_sts,
  input logic              cfg_err_sts
);
  logic ctrl_wr, hit_tgt, hit_other, bad_sel;

  assign ctrl_wr   = cfg_we && (cfg_sel == 2'd0);
  assign hit_tgt   = tgt_b ? b_req : a_req;
  assign hit_other = tgt_b ? (a_req && !b_req) : (b_req && !a_req);
  assign bad_sel   = ctrl_wr && cfg_wdata[4] && (cfg_wdata[3:0] == 4'd7) &&
                     (cfg_wdata[10:8] != 3'd0) && (cfg_wdata[10:8] != 3'd4);

  AST_A_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    a_req |=> a_rvalid); // R1
  AST_B_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    b_req |=> b_rvalid); // R1
  AST_IDLE_STAYS_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!diag_armed && !ctrl_wr) |=> !diag_armed); // R2
  AST_MODE_GATES_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (cfg_wdata[3:0] != 4'd7)) |=> !diag_armed); // R2
  AST_ONE_SHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_armed && !cfg_we && hit_tgt) |=> !diag_armed); // R3
  AST_OTHER_PORT_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_armed && !cfg_we && hit_other) |=> diag_armed); // R4
  AST_BAD_SEL_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    bad_sel |=> (!diag_armed && cfg_err_sts)); // R6
  AST_FIQ_WITH_DED: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req |-> ded_sts); // R9

endmodule

bind ecc_inject_rdpath ecc_inject_rdpath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .cfg_wdata   (cfg_wdata),
  .a_req       (a_req),
  .b_req       (b_req),
  .a_rvalid    (a_rvalid),
  .b_rvalid    (b_rvalid),
  .diag_armed  (diag_armed),
  .tgt_b       (arm_tgt_b),
  .fiq_req     (fiq_req),
  .ded_sts     (ded_sts),
  .cfg_err_sts (cfg_err_sts)
);

// File: tb/ecc_inject_rdpath_test.sv
module ecc_inject_rdpath_test;
  localparam int DW = 64;
  localparam int AW = 4;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'd0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          a_req = 1'b0, b_req = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_mem_data, b_mem_data, a_rdata, b_rdata;
  logic [CW-1:0] a_mem_chk, b_mem_chk;
  logic          a_rvalid, b_rvalid, diag_armed, sec_sts, ded_sts, cfg_err_sts;
  logic          err_port, fiq_req;
  logic [AW-1:0] err_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // memory model contents: a fixed arithmetic pattern per address
  function automatic logic [DW-1:0] mdata(input logic [AW-1:0] ad);
    return (64'h9E3779B97F4A7C15 * (64'(ad) + 64'd1)) ^ {16{ad}};
  endfunction

  // encoder per R7: walk positions 1..., skipping powers of two for data
  function automatic logic [CW-1:0] enc(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int pos, di;
    c = '0;
    di = 0;
    for (pos = 1; di < DW; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int j = 0; j < CW - 1; j++)
          if (((pos >> j) & 1) == 1) c[j] = c[j] ^ d[di];
        di++;
      end
    end
    c[CW-1] = ^{c[CW-2:0], d};
    return c;
  endfunction

  assign a_mem_data = mdata(a_addr);
  assign b_mem_data = mdata(b_addr);
  assign a_mem_chk  = enc(a_mem_data);
  assign b_mem_chk  = enc(b_mem_data);

  ecc_inject_rdpath #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata),
    .a_req(a_req), .a_addr(a_addr), .a_mem_data(a_mem_data),
    .a_mem_chk(a_mem_chk), .a_rvalid(a_rvalid), .a_rdata(a_rdata),
    .b_req(b_req), .b_addr(b_addr), .b_mem_data(b_mem_data),
    .b_mem_chk(b_mem_chk), .b_rvalid(b_rvalid), .b_rdata(b_rdata),
    .diag_armed(diag_armed), .sec_sts(sec_sts), .ded_sts(ded_sts),
    .cfg_err_sts(cfg_err_sts), .err_port(err_port), .err_addr(err_addr),
    .fiq_req(fiq_req)
  );

  task automatic check(input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [DW-1:0] dat);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = dat;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  function automatic logic [DW-1:0] ctrlw(input logic [3:0] md, input bit tr,
                                         input logic [2:0] bs);
    return DW'({bs, 3'b000, tr, md});
  endfunction

  task automatic rd(input bit pb, input logic [AW-1:0] ad);
    if (pb) begin b_req = 1'b1; b_addr = ad; end
    else    begin a_req = 1'b1; a_addr = ad; end
    @(negedge clk);
    a_req = 1'b0; b_req = 1'b0;
  endtask

  function automatic logic [DW-1:0] pdata(input bit pb);
    return pb ? b_rdata : a_rdata;
  endfunction

  function automatic logic pvalid(input bit pb);
    return pb ? b_rvalid : a_rvalid;
  endfunction

  // arm an injection of mask m on port pb, read addr ad, check, clear, re-read
  task automatic inject_case(input logic [71:0] m, input bit pb,
                             input logic [AW-1:0] ad, input bit dbl);
    logic [DW-1:0] expd;
    wr(2'd1, m[63:0]);
    wr(2'd2, DW'(m[71:64]));
    wr(2'd0, ctrlw(4'd7, 1'b1, pb ? 3'd4 : 3'd0));
    rd(pb, ad);
    expd = dbl ? (mdata(ad) ^ m[63:0]) : mdata(ad);
    // R8 single corrected / R9 double passed raw with FIQ / R10 capture / R3 disarm
    check(dbl ? "R9 double inject" : "R8 R7 single inject",
          {pdata(pb), pvalid(pb), sec_sts, ded_sts, fiq_req, diag_armed,
           err_port, err_addr},
          {expd, 1'b1, !dbl, dbl, dbl, 1'b0, pb, ad});
    wr(2'd3, DW'(4'hF));
    rd(pb, ad);
    // R3 one-shot: follow-up read is clean; R11 status cleared
    check("R3 R11 follow-up clean",
          {pdata(pb), sec_sts, ded_sts, fiq_req, err_port, err_addr},
          {mdata(ad), 1'b0, 1'b0, 1'b0, 1'b0, AW'(0)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // reset state
    check("R1 reset state",
          {a_rvalid, b_rvalid, diag_armed, sec_sts, ded_sts, cfg_err_sts, fiq_req},
          7'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R5 plain reads on both ports
    for (int k = 0; k < 16; k++) begin
      rd(k[0], AW'(k));
      check("R1 R5 plain read",
            {pdata(k[0]), pvalid(k[0]), sec_sts, ded_sts, fiq_req},
            {mdata(AW'(k)), 1'b1, 3'b000});
    end

    // masks nonzero for the no-arm cases
    wr(2'd1, 64'h3);
    wr(2'd2, 64'h0);

    // R2 wrong mode does not arm
    wr(2'd0, ctrlw(4'd3, 1'b1, 3'd0));
    check("R2 mode 3 no arm", {63'b0, diag_armed}, 64'b0);
    rd(1'b0, 4'd5);
    check("R2 mode 3 read clean", {a_rdata, ded_sts}, {mdata(4'd5), 1'b0});

    // R2 trigger bit clear does not arm
    wr(2'd0, ctrlw(4'd7, 1'b0, 3'd0));
    check("R2 no trigger no arm", {63'b0, diag_armed}, 64'b0);

    // R6 illegal port select
    wr(2'd0, ctrlw(4'd7, 1'b1, 3'd2));
    check("R6 illegal select", {diag_armed, cfg_err_sts}, 2'b01);
    rd(1'b0, 4'd6);
    rd(1'b1, 4'd6);
    check("R6 reads clean after illegal select",
          {a_rdata, b_rdata, ded_sts, sec_sts}, {mdata(4'd6), mdata(4'd6), 2'b00});
    wr(2'd3, 64'h4);
    check("R11 clear config error", {63'b0, cfg_err_sts}, 64'b0);

    // R2 R4 arm for B, read A: unmodified, stays armed
    wr(2'd0, ctrlw(4'd7, 1'b1, 3'd4));
    check("R2 armed for B", {63'b0, diag_armed}, 64'b1);
    rd(1'b0, 4'd9);
    check("R4 other port clean and still armed",
          {a_rdata, diag_armed, ded_sts, sec_sts}, {mdata(4'd9), 3'b100});
    rd(1'b1, 4'd9);
    check("R3 R9 target port injected",
          {b_rdata, diag_armed, ded_sts, fiq_req, err_port, err_addr},
          {mdata(4'd9) ^ 64'h3, 1'b0, 1'b1, 1'b1, 1'b1, 4'd9});
    @(negedge clk);
    check("R9 fiq is a single pulse", {fiq_req, ded_sts}, 2'b01);
    wr(2'd3, 64'h2);
    check("R11 ded clear keeps capture",
          {ded_sts, err_port, err_addr}, {1'b0, 1'b1, 4'd9});
    wr(2'd3, 64'h8);
    check("R11 capture cleared", {err_port, err_addr}, {1'b0, 4'd0});

    // R2 re-writing control without trigger disarms
    wr(2'd0, ctrlw(4'd7, 1'b1, 3'd0));
    wr(2'd0, ctrlw(4'd7, 1'b0, 3'd0));
    check("R2 rewrite disarms", {63'b0, diag_armed}, 64'b0);

    // R7 R8 exhaustive single-bit sweep
    n = 0;
    for (int i = 0; i < 72; i++) begin
      inject_case(72'b1 << i, n[0], AW'(n), 1'b0);
      n++;
    end
    // R9 exhaustive double-bit sweep: 2556 pairs
    for (int i = 0; i < 72; i++) begin
      for (int j = i + 1; j < 72; j++) begin
        inject_case((72'b1 << i) | (72'b1 << j), n[0], AW'(n), 1'b1);
        n++;
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule